// File: doc/BRIEF.md
# Parallel Binary-to-Residue Forward Converter

This block converts an unsigned binary word of `NUM_SEG * SEG_W` bits into its residue with respect to one modulus of the form 2^n − k or 2^n + k. Here n is `SEG_W`, k is `K`, and `PLUS_MOD` selects the sign. The word is cut into `NUM_SEG` slices of n bits each. Slice i sits at bits [(i+1)n−1 : in]. Because 2^n is congruent to k or to −k under the modulus, each slice carries the weight k^i. The block reduces that weight ahead of time at elaboration, so no lookup table or memory is involved.

Every slice is multiplied by its reduced weight, and each product is reduced below the modulus on its own. The reduced terms are then folded pairwise through a chain of modular 3:2 compressors, and a final modular adder resolves the remaining pair. For the 2^n + k case, each odd slice is complemented before its multiply, which turns its negative weight into a positive one. The k+1 left over from every odd slice is summed into one constant term that enters the chain.

A small wrapper captures the input word when `in_valid` is high and raises `out_valid` for the following cycle. A two-state machine tracks this. State `ST_EMPTY` moves to `ST_VALID` on `in_valid` (transition LOAD) and stays in `ST_EMPTY` otherwise (transition STAY_EMPTY). State `ST_VALID` moves back to `ST_EMPTY` when `in_valid` is low (transition DRAIN) and stays in `ST_VALID` on a new `in_valid` (transition RELOAD).

Top module: `rns_fwd_conv`

## Requirements
- R1: With `PLUS_MOD`=0, the residue equals X mod (2^n − k), where X is the unsigned input word and slice i occupies bits [(i+1)n−1 : in].
- R2: With `PLUS_MOD`=1, the residue equals X mod (2^n + k), using the same slice layout.
- R3: The residue is n bits wide when `PLUS_MOD`=0 and n+1 bits wide when `PLUS_MOD`=1. Whenever `out_valid` is high, its value is strictly below the modulus.
- R4: The result is correct for every k with 0 < k and ceil(log2(k+1)) ≤ n/2, including k = 3 and k = 2^(n/2) − 1.
- R5: An input of zero and any exact multiple of the modulus give residue 0. An all-ones input gives (2^(jn) − 1) mod the modulus.
- R6: When `in_valid` is high at a rising edge, `out_valid` is high in the cycle after that edge, and `out_residue` then holds the residue of the word sampled at that edge.
- R7: When `in_valid` is low at a rising edge, `out_valid` is low after that edge. `out_residue` keeps its previous value even if `in_data` changes.
- R8: While `rst_n` is low and just after reset, `out_valid` is 0 and `out_residue` is 0.
- R9: The state machine moves `ST_EMPTY`→`ST_VALID` on `in_valid` and moves `ST_VALID`→`ST_EMPTY` without it. `out_valid` is high only in `ST_VALID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture strobe for `in_data` |
| in_data | input | NUM_SEG*SEG_W | Unsigned binary word to convert |
| out_valid | output | 1 | High in the cycle after a capture |
| out_residue | output | SEG_W or SEG_W+1 | Residue of the last captured word |

## Verification
A wrong reduced weight or a wrong correction constant shows up as a mismatch against X mod M. It appears in the cycle right after the faulty word is captured, and only for words whose affected slice is nonzero, so the stimulus gives every slice a nonzero value as well as zero. A fault in the pairwise modular reduction tends to push the output to M or above, and that is visible in the same cycle. A fault in the state machine or in the capture register shows up one cycle after the strobe, either as `out_valid` at the wrong level or as a residue that drifts while `in_valid` is low.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

    // Residue width: n bits below 2^n, n+1 bits above it.
    function automatic int mod_width(input int seg_w, input bit plus_mod);
        return plus_mod ? seg_w + 1 : seg_w;
    endfunction

    function automatic longint unsigned modulus(input int seg_w,
                                                input longint unsigned k,
                                                input bit plus_mod);
        longint unsigned base;
        base = 64'(1) << seg_w;
        return plus_mod ? base + k : base - k;
    endfunction

    // k^idx reduced by the modulus, evaluated at elaboration.
    function automatic longint unsigned seg_weight(input int seg_w,
                                                   input longint unsigned k,
                                                   input bit plus_mod,
                                                   input int idx);
        longint unsigned m;
        longint unsigned w;
        m = modulus(seg_w, k, plus_mod);
        w = 64'(1) % m;
        for (int i = 0; i < idx; i++) begin
            w = (w * k) % m;
        end
        return w;
    endfunction

    // Sum over odd slices of weight*(k+1), reduced; only used above 2^n.
    function automatic longint unsigned odd_fixup(input int seg_w,
                                                  input longint unsigned k,
                                                  input int num_seg);
        longint unsigned m;
        longint unsigned acc;
        m = modulus(seg_w, k, 1'b1);
        acc = 0;
        for (int i = 1; i < num_seg; i += 2) begin
            acc = (acc + (seg_weight(seg_w, k, 1'b1, i) * (k + 1)) % m) % m;
        end
        return acc;
    endfunction

endpackage

// File: rtl/rns_mod_reduce.sv
module rns_mod_reduce #(
    parameter int              IN_W = 16,
    parameter int              MW   = 8,
    parameter longint unsigned MODV = 253
) (
    input  logic [IN_W-1:0] val,
    output logic [MW-1:0]   res
);
    localparam int RW = IN_W + 2;
    localparam int TOP_SHIFT = (IN_W > MW) ? IN_W - MW + 1 : 1;
    localparam logic [RW-1:0] MOD_EXT = RW'(MODV);

    logic [RW-1:0] rem;

    // Restoring remainder: subtract shifted copies of the modulus.
    always_comb begin
        rem = RW'(val);
        for (int s = TOP_SHIFT; s >= 0; s--) begin
            if (rem >= (MOD_EXT << s)) begin
                rem = rem - (MOD_EXT << s);
            end
        end
        res = MW'(rem);
    end
endmodule

// File: rtl/rns_seg_term.sv
module rns_seg_term #(
    parameter int              SEG_W    = 8,
    parameter int              MW       = 8,
    parameter int unsigned     K        = 3,
    parameter bit              PLUS_MOD = 1'b0,
    parameter bit              NEG      = 1'b0,
    parameter longint unsigned MODV     = 253,
    parameter longint unsigned WGT      = 1
) (
    input  logic [SEG_W-1:0] seg,
    output logic [MW-1:0]    term
);
    localparam int PW = SEG_W + MW;
    localparam int KW = $clog2(K + 1);
    localparam int FW = MW + KW + 1;
    localparam logic [MW-1:0] WGT_V = MW'(WGT);

    logic [SEG_W-1:0] seg_in;
    logic [PW-1:0]    prod;

    // Odd slices above 2^n enter complemented; their k+1 goes to the fixup term.
    assign seg_in = NEG ? ~seg : seg;
    assign prod   = PW'(seg_in) * PW'(WGT_V);

    generate
        if (!PLUS_MOD) begin : g_fold
            // 2^n is congruent to k: fold the high part back once.
            logic [MW-1:0]    hi;
            logic [SEG_W-1:0] lo;
            logic [FW-1:0]    folded;
            assign hi     = prod[PW-1:SEG_W];
            assign lo     = prod[SEG_W-1:0];
            assign folded = FW'(hi) * FW'(K) + FW'(lo);
            rns_mod_reduce #(.IN_W(FW), .MW(MW), .MODV(MODV)) u_red (
                .val(folded), .res(term)
            );
        end else begin : g_direct
            rns_mod_reduce #(.IN_W(PW), .MW(MW), .MODV(MODV)) u_red (
                .val(prod), .res(term)
            );
        end
    endgenerate
endmodule

// File: rtl/rns_csa_mod.sv
module rns_csa_mod #(
    parameter int              MW   = 8,
    parameter longint unsigned MODV = 253
) (
    input  logic [MW-1:0] a,
    input  logic [MW-1:0] b,
    input  logic [MW-1:0] c,
    output logic [MW-1:0] s_red,
    output logic [MW-1:0] c_red
);
    logic [MW-1:0] sum_v;
    logic [MW:0]   car_v;

    assign sum_v = a ^ b ^ c;
    assign car_v = {(a & b) | (a & c) | (b & c), 1'b0};

    // Each vector is brought back below the modulus before the next stage.
    rns_mod_reduce #(.IN_W(MW), .MW(MW), .MODV(MODV)) u_rs (
        .val(sum_v), .res(s_red)
    );
    rns_mod_reduce #(.IN_W(MW + 1), .MW(MW), .MODV(MODV)) u_rc (
        .val(car_v), .res(c_red)
    );
endmodule

// File: rtl/rns_fwd_core.sv
module rns_fwd_core #(
    parameter int          SEG_W    = 8,
    parameter int          NUM_SEG  = 4,
    parameter int unsigned K        = 3,
    parameter bit          PLUS_MOD = 1'b0
) (
    input  logic [NUM_SEG*SEG_W-1:0]                       word,
    output logic [rns_fwd_pkg::mod_width(SEG_W, PLUS_MOD)-1:0] residue
);
    import rns_fwd_pkg::*;

    localparam int              MW   = mod_width(SEG_W, PLUS_MOD);
    localparam longint unsigned MODV = modulus(SEG_W, 64'(K), PLUS_MOD);
    localparam int              NT   = NUM_SEG + (PLUS_MOD ? 1 : 0);
    localparam logic [MW:0]     MOD_EXT = (MW + 1)'(MODV);

    logic [MW-1:0] term [NT];
    logic [MW-1:0] pa   [NT-1];
    logic [MW-1:0] pb   [NT-1];
    logic [MW:0]   fin_sum;

    // Stage one: one reduced constant product per slice.
    generate
        for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
            rns_seg_term #(
                .SEG_W(SEG_W), .MW(MW), .K(K), .PLUS_MOD(PLUS_MOD),
                .NEG(PLUS_MOD && (i % 2 == 1)), .MODV(MODV),
                .WGT(seg_weight(SEG_W, 64'(K), PLUS_MOD, i))
            ) u_term (
                .seg(word[(i+1)*SEG_W-1 -: SEG_W]), .term(term[i])
            );
        end
        if (PLUS_MOD) begin : g_fix
            assign term[NUM_SEG] = MW'(odd_fixup(SEG_W, 64'(K), NUM_SEG));
        end
    endgenerate

    // Stage two: modular carry-save chain.
    assign pa[0] = term[0];
    assign pb[0] = term[1];
    generate
        for (genvar t = 2; t < NT; t++) begin : g_csa
            rns_csa_mod #(.MW(MW), .MODV(MODV)) u_csa (
                .a(pa[t-2]), .b(pb[t-2]), .c(term[t]),
                .s_red(pa[t-1]), .c_red(pb[t-1])
            );
        end
    endgenerate

    // Final modular adder: both inputs are below M, so one subtraction suffices.
    always_comb begin
        fin_sum = {1'b0, pa[NT-2]} + {1'b0, pb[NT-2]};
        if (fin_sum >= MOD_EXT) begin
            residue = MW'(fin_sum - MOD_EXT);
        end else begin
            residue = MW'(fin_sum);
        end
    end
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
    parameter int          SEG_W    = 8,
    parameter int          NUM_SEG  = 4,
    parameter int unsigned K        = 3,
    parameter bit          PLUS_MOD = 1'b0
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             in_valid,
    input  logic [NUM_SEG*SEG_W-1:0]                         in_data,
    output logic                                             out_valid,
    output logic [rns_fwd_pkg::mod_width(SEG_W, PLUS_MOD)-1:0] out_residue
);
    import rns_fwd_pkg::*;

    localparam int              IN_W = NUM_SEG * SEG_W;
    localparam int              MW   = mod_width(SEG_W, PLUS_MOD);
    localparam longint unsigned MODV = modulus(SEG_W, 64'(K), PLUS_MOD);

    typedef enum logic {ST_EMPTY = 1'b0, ST_VALID = 1'b1} conv_state_e;

    conv_state_e     state_q;
    conv_state_e     state_d;
    logic [IN_W-1:0] data_q;

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_VALID : ST_EMPTY; // LOAD / STAY_EMPTY
            ST_VALID: state_d = in_valid ? ST_VALID : ST_EMPTY; // RELOAD / DRAIN
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (in_valid) begin
            data_q <= in_data;
        end
    end

    // Output process.
    always_comb begin
        out_valid = (state_q == ST_VALID);
    end

    rns_fwd_core #(
        .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .K(K), .PLUS_MOD(PLUS_MOD)
    ) u_core (
        .word(in_data_sel()), .residue(out_residue)
    );

    function automatic logic [IN_W-1:0] in_data_sel();
        return data_q;
    endfunction

    // R3: residue stays below the modulus.
    assert_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (64'(out_residue) < MODV));

    // R1, R2: residue agrees with a plain division remainder.
    assert_residue_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (64'(out_residue) == (64'(data_q) % MODV)));

    // R6: a strobe yields valid output one cycle later.
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: no strobe means no valid output next cycle.
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: residue holds without a strobe.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_residue));
endmodule

// File: tb/sim_rns_fwd_conv.sv
module sim_rns_fwd_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;

    logic       v0, v1, v2, v3;
    logic [7:0] r0, r3;
    logic [8:0] r1, r2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam longint unsigned M0 = 253; // 2^8 - 3
    localparam longint unsigned M1 = 271; // 2^8 + 15
    localparam longint unsigned M2 = 259; // 2^8 + 3
    localparam longint unsigned M3 = 241; // 2^8 - 15

    localparam logic [31:0] VEC [14] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_00FF,
        32'h0000_FF00, 32'h00FF_0000, 32'hFF00_0000, 32'h1234_5678,
        32'hDEAD_BEEF, 32'h8000_0001, 32'hF14E_9A00, 32'hF24A_4CC0,
        32'h0F0F_F0F0, 32'hA5C3_3C5A
    };

    always #10 clk = ~clk;

    rns_fwd_conv #(.SEG_W(8), .NUM_SEG(4), .K(3),  .PLUS_MOD(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v0), .out_residue(r0));
    rns_fwd_conv #(.SEG_W(8), .NUM_SEG(4), .K(15), .PLUS_MOD(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v1), .out_residue(r1));
    rns_fwd_conv #(.SEG_W(8), .NUM_SEG(4), .K(3),  .PLUS_MOD(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v2), .out_residue(r2));
    rns_fwd_conv #(.SEG_W(8), .NUM_SEG(4), .K(15), .PLUS_MOD(1'b0)) u3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v3), .out_residue(r3));

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input logic [31:0] x);
        check("R1 u0 k=3 minus",  64'(r0), 64'(x) % M0);
        check("R2 u1 k=15 plus",  64'(r1), 64'(x) % M1);
        check("R2 u2 k=3 plus",   64'(r2), 64'(x) % M2);
        check("R4 u3 k=15 minus", 64'(r3), 64'(x) % M3);
        check("R3 u1 below M", 64'(64'(r1) < M1), 64'd1);
    endtask

    // Strobe one word, then check in the following cycle.
    task automatic convert(input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~x;
        check("R6 R9 out_valid after strobe", 64'(v0 & v1 & v2 & v3), 64'd1);
        check_all(x);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state.
        #25;
        check("R8 out_valid in reset", 64'(v0 | v1 | v2 | v3), 64'd0);
        check("R8 residue in reset", 64'(r0) + 64'(r1) + 64'(r2) + 64'(r3), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", 64'(v0), 64'd0);
        check("R8 residue after reset", 64'(r0), 64'd0);

        // Table walk: R1, R2, R4.
        for (int i = 0; i < 14; i++) begin
            convert(VEC[i]);
        end

        // R5 corner cases.
        convert(32'd0);
        check("R5 zero gives 0", 64'(r0) + 64'(r2), 64'd0);
        convert(32'(M0 * 64'd16000000));
        check("R5 multiple of 253", 64'(r0), 64'd0);
        convert(32'(M1 * 64'd15000000));
        check("R5 multiple of 271", 64'(r1), 64'd0);
        convert(32'hFFFF_FFFF);
        check("R5 all ones u2", 64'(r2), 64'hFFFF_FFFF % M2);

        // R7: no strobe, data changes, residue holds.
        convert(32'h1357_9BDF);
        @(negedge clk);
        in_data = 32'h0246_8ACE;
        check("R7 out_valid low without strobe", 64'(v0 | v1), 64'd0);
        check("R7 residue holds u0", 64'(r0), 64'h1357_9BDF % M0);
        @(negedge clk);
        check("R7 residue holds u1", 64'(r1), 64'h1357_9BDF % M1);

        // R9: back-to-back strobes keep ST_VALID.
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h0000_FEED;
        @(negedge clk);
        in_data  = 32'hBEEF_0000;
        check("R9 valid on first strobe", 64'(v0), 64'd1);
        check("R1 first back-to-back", 64'(r0), 64'h0000_FEED % M0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 valid held on reload", 64'(v0), 64'd1);
        check("R2 second back-to-back", 64'(r2), 64'hBEEF_0000 % M2);
        @(negedge clk);
        check("R9 drains to empty", 64'(v0), 64'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule